// File: doc/BRIEF.md
# Sync Slice Threshold Tracker

This block chooses the level at which a composite-video input is sliced to find sync. It drives a 12-bit code to an external DAC that sets one comparator input, and it watches the comparator result (high while the video sits below the code). A sampled 12-bit ADC stream gives the block the sync-tip voltage. After reset the code climbs in fixed steps, one step per line period, until the comparator shows sync pulses of plausible width. From then on the code follows the measured sync tip plus a programmable margin, so the slice sits just under black level.

Each sync pulse starts an 8-sample average of the ADC. The averages feed a 23-deep running median, so that single spikes and slow changes in picture brightness do not move the slice level much. Right after each accepted sync pulse the code moves up to a separate burst-detect level. It comes back down when burst handling reports completion, or after a bounded time when no burst is present. New tip readings enter the filter only after that window closes. Lock is declared after a run of well-formed pulses. A long stretch without sync sends the block back to searching.

Top module: `sync_slice_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dac_code` is 0 and `locked` and `median_ready` are 0.
- R2: While searching, the code starts at 0 and rises by SEARCH_STEP once per LINE_CYCLES clock cycles, wrapping to 0 past 4095. The first step appears LINE_CYCLES+1 cycles after reset is released.
- R3: Once a sync pulse of valid width has been seen, outside the burst window `dac_code` equals `tip_level + sync_ofs`, saturated at 4095.
- R4: A tip reading is the truncated mean of the 8 ADC samples that are valid on and after the cycle in which `cmp_in` rises.
- R5: `tip_level` is the most recent tip reading until 23 readings have entered the filter. After that it is the 12th smallest of the last 23 readings, and `median_ready` is 1 and stays 1.
- R6: A tip reading enters the filter only after the comparator pulse and any burst window that follows it have ended, so `tip_level` does not change inside the burst window.
- R7: From the cycle after an accepted sync pulse ends until `burst_done` is seen, `dac_code` equals `tip_level + burst_ofs`, saturated at 4095.
- R8: If `burst_done` does not arrive, the burst window closes by itself after BURST_MAX cycles and the code returns to the sync level.
- R9: `locked` rises on the 16th consecutive pulse whose width (cycles of `cmp_in` high) lies in [`width_min`, `width_max`]. A pulse outside that window before lock restarts the count.
- R10: After 64 line periods with no accepted pulse, the block returns to searching. `locked` falls and the search code restarts at 0.
- R11: While searching, comparator pulses outside the width window are ignored and stepping continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Comparator result, 1 while video is below the code |
| adc_valid | input | 1 | ADC sample strobe |
| adc_data | input | 12 | ADC sample |
| burst_done | input | 1 | Pulse: burst handling finished for this line |
| sync_ofs | input | 12 | Margin added to the tip for sync slicing |
| burst_ofs | input | 12 | Margin added to the tip for burst detection |
| width_min | input | 8 | Shortest accepted sync width, cycles |
| width_max | input | 8 | Longest accepted sync width, cycles |
| dac_code | output | 12 | Threshold code to the DAC |
| locked | output | 1 | Lock established |
| median_ready | output | 1 | Median filter holds 23 readings |
| tip_level | output | 12 | Filtered sync-tip level in use |

## Verification
The bench drives pulses that are too wide while the search code is already above the tip. A design that accepted them would jump to the tip-plus-margin level instead of continuing to step. An ADC ramp inside the pulse catches an average that starts one sample late or rounds up, and a change in reading between lines shows whether the level updates before burst handling has finished. A full window with a spike line checks that the median picks the 12th smallest value. Saturation, a missing burst acknowledgement, a bad-width pulse midway through the lock count and a 64-line loss of sync each show up as a wrong code, a threshold stuck at the burst level, early lock, or lock that never drops.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int CODE_W   = 12;
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_ACQ    = 2'd1,
        ST_LOCK   = 2'd2
    } acq_state_e;

    typedef struct packed {
        logic  valid;
        code_t value;
    } tip_sample_t;

    function automatic code_t add_sat(code_t a, code_t b);
        logic [CODE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CODE_W] ? '1 : s[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/tip_avg.sv
module tip_avg
    import sst_pkg::*;
#(
    parameter int AVG_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        smp_valid,
    input  code_t       smp,
    output tip_sample_t res
);
    localparam int N     = 1 << AVG_LOG2;
    localparam int SUM_W = CODE_W + AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] total;

    assign total = sum + SUM_W'(smp);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            sum       <= '0;
            res.valid <= 1'b0;
            res.value <= '0;
        end else begin
            res.valid <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sum    <= smp_valid ? SUM_W'(smp) : '0;
                    cnt    <= smp_valid ? CNT_W'(1) : '0;
                end
            end else if (smp_valid) begin
                if (cnt == CNT_W'(N - 1)) begin
                    res.valid <= 1'b1;
                    res.value <= code_t'(total >> AVG_LOG2);
                    active    <= 1'b0;
                end else begin
                    sum <= total;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: a result only follows an open collection window
    assert_avg_window_R4: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> $past(active));
endmodule

// File: rtl/tip_median.sv
module tip_median
    import sst_pkg::*;
#(
    parameter int DEPTH = 23
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  code_t din,
    output logic  busy,
    output code_t med_q,
    output logic  med_ok
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int MID    = DEPTH / 2;

    code_t             ring [DEPTH];
    code_t             srt  [DEPTH];
    logic [IDX_W-1:0]  wptr;
    logic [FILL_W-1:0] fill;
    logic [IDX_W-1:0]  pos;
    logic [IDX_W-1:0]  pm1;
    logic [IDX_W-1:0]  old_idx;

    assign pm1 = pos - 1'b1;

    always_comb begin
        old_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (srt[k] == ring[wptr]) old_idx = IDX_W'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                ring[k] <= '0;
                srt[k]  <= '0;
            end
            wptr   <= '0;
            fill   <= '0;
            pos    <= '0;
            busy   <= 1'b0;
            med_q  <= '0;
            med_ok <= 1'b0;
        end else begin
            if (!busy) begin
                med_q  <= srt[MID];
                med_ok <= (fill == FILL_W'(DEPTH));
            end
            if (push) begin
                ring[wptr] <= din;
                wptr <= (wptr == IDX_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
                if (fill == FILL_W'(DEPTH)) begin
                    for (int k = 0; k < DEPTH - 1; k++) begin
                        srt[k] <= (IDX_W'(k) >= old_idx) ? srt[k+1] : srt[k];
                    end
                    srt[DEPTH-1] <= din;
                    pos  <= IDX_W'(DEPTH - 1);
                    busy <= 1'b1;
                end else begin
                    srt[fill] <= din;
                    pos  <= IDX_W'(fill);
                    busy <= (fill != '0);
                    fill <= fill + 1'b1;
                end
            end else if (busy) begin
                if (srt[pm1] > srt[pos]) begin
                    srt[pm1] <= srt[pos];
                    srt[pos] <= srt[pm1];
                    pos      <= pm1;
                    if (pm1 == '0) busy <= 1'b0;
                end else begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // R5: the shadow array is ordered whenever no insertion is running
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
        assert_sorted_R5: assert property (@(posedge clk) disable iff (rst)
            (!busy && (FILL_W'(g + 1) < fill)) |-> (srt[g] <= srt[g+1]));
    end

    // R5: the owner never pushes during an insertion pass
    assert_push_idle_R5: assert property (@(posedge clk) disable iff (rst)
        push |-> !busy);
endmodule

// File: rtl/sync_acq.sv
module sync_acq
    import sst_pkg::*;
#(
    parameter int LOCK_LINES  = 16,
    parameter int LOSS_LINES  = 64,
    parameter int LINE_CYCLES = 1024,
    parameter int BURST_MAX   = 128,
    parameter int SEARCH_STEP = 16,
    parameter int WID_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_in,
    input  logic             burst_done,
    input  logic [WID_W-1:0] wmin,
    input  logic [WID_W-1:0] wmax,
    output acq_state_e       state,
    output code_t            search_code,
    output logic             burst_phase,
    output logic             sync_rise,
    output logic             hold_upd
);
    localparam int TMR_W = $clog2(LINE_CYCLES + 1);
    localparam int BST_W = $clog2(BURST_MAX + 1);
    localparam int LCK_W = $clog2(LOCK_LINES + 1);
    localparam int LOS_W = $clog2(LOSS_LINES + 1);

    logic             cmp_q;
    logic [WID_W-1:0] wid;
    logic [TMR_W-1:0] timer;
    logic [BST_W-1:0] bcnt;
    logic [LCK_W-1:0] good_cnt;
    logic [LOS_W-1:0] miss_cnt;
    logic             sync_fall, width_ok, good, bad, line_end;
    logic [CODE_W:0]  next_code;

    assign sync_rise = cmp_in & ~cmp_q & ~burst_phase;
    assign sync_fall = ~cmp_in & cmp_q & ~burst_phase;
    assign width_ok  = (wid >= wmin) && (wid <= wmax);
    assign good      = sync_fall & width_ok;
    assign bad       = sync_fall & ~width_ok;
    assign line_end  = (timer == TMR_W'(LINE_CYCLES - 1));
    assign hold_upd  = cmp_in | cmp_q | burst_phase;
    assign next_code = {1'b0, search_code} + (CODE_W + 1)'(SEARCH_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_SEARCH;
            search_code <= '0;
            cmp_q       <= 1'b0;
            wid         <= '0;
            timer       <= '0;
            bcnt        <= '0;
            burst_phase <= 1'b0;
            good_cnt    <= '0;
            miss_cnt    <= '0;
        end else begin
            cmp_q <= cmp_in;
            if (cmp_in) begin
                if (!cmp_q) wid <= WID_W'(1);
                else if (wid != '1) wid <= wid + 1'b1;
            end

            timer <= (good || line_end) ? '0 : timer + 1'b1;

            if (good) begin
                burst_phase <= 1'b1;
                bcnt        <= '0;
            end else if (burst_phase) begin
                if (burst_done || bcnt == BST_W'(BURST_MAX - 1)) burst_phase <= 1'b0;
                else bcnt <= bcnt + 1'b1;
            end

            unique case (state)
                ST_SEARCH: begin
                    if (good) begin
                        state    <= ST_ACQ;
                        good_cnt <= LCK_W'(1);
                        miss_cnt <= '0;
                    end else if (line_end) begin
                        search_code <= next_code[CODE_W] ? '0 : next_code[CODE_W-1:0];
                    end
                end
                default: begin
                    if (good) begin
                        miss_cnt <= '0;
                        if (state == ST_ACQ) begin
                            if (good_cnt == LCK_W'(LOCK_LINES - 1)) state <= ST_LOCK;
                            else good_cnt <= good_cnt + 1'b1;
                        end
                    end else if (bad && state == ST_ACQ) begin
                        good_cnt <= '0;
                    end else if (line_end) begin
                        if (miss_cnt == LOS_W'(LOSS_LINES - 1)) begin
                            state       <= ST_SEARCH;
                            search_code <= '0;
                            good_cnt    <= '0;
                            miss_cnt    <= '0;
                        end else begin
                            miss_cnt <= miss_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R9: lock is entered only from acquisition on an accepted pulse
    assert_lock_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK && $past(state) != ST_LOCK) |-> $past(state == ST_ACQ && good));

    // R8: the burst window never outlives its bound
    assert_burst_bound_R8: assert property (@(posedge clk) disable iff (rst)
        burst_phase |-> (bcnt < BST_W'(BURST_MAX)));

    // R10: re-entering search restarts the code
    assert_search_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEARCH && $past(state) != ST_SEARCH) |-> (search_code == '0));
endmodule

// File: rtl/sync_slice_tracker.sv
module sync_slice_tracker
    import sst_pkg::*;
#(
    parameter int AVG_LOG2    = 3,
    parameter int MED_DEPTH   = 23,
    parameter int LOCK_LINES  = 16,
    parameter int LOSS_LINES  = 64,
    parameter int LINE_CYCLES = 1024,
    parameter int BURST_MAX   = 128,
    parameter int SEARCH_STEP = 16,
    parameter int WID_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmp_in,
    input  logic                 adc_valid,
    input  logic [CODE_W-1:0]    adc_data,
    input  logic                 burst_done,
    input  logic [CODE_W-1:0]    sync_ofs,
    input  logic [CODE_W-1:0]    burst_ofs,
    input  logic [WID_W-1:0]     width_min,
    input  logic [WID_W-1:0]     width_max,
    output logic [CODE_W-1:0]    dac_code,
    output logic                 locked,
    output logic                 median_ready,
    output logic [CODE_W-1:0]    tip_level
);
    acq_state_e  state;
    code_t       search_code;
    logic        burst_phase, sync_rise, hold_upd;
    tip_sample_t avg;
    logic        pend, push, raw_ok, med_busy, med_ok;
    code_t       pend_val, raw_q, med_q, base, thr;

    sync_acq #(
        .LOCK_LINES (LOCK_LINES),
        .LOSS_LINES (LOSS_LINES),
        .LINE_CYCLES(LINE_CYCLES),
        .BURST_MAX  (BURST_MAX),
        .SEARCH_STEP(SEARCH_STEP),
        .WID_W      (WID_W)
    ) u_acq (
        .clk        (clk),
        .rst        (rst),
        .cmp_in     (cmp_in),
        .burst_done (burst_done),
        .wmin       (width_min),
        .wmax       (width_max),
        .state      (state),
        .search_code(search_code),
        .burst_phase(burst_phase),
        .sync_rise  (sync_rise),
        .hold_upd   (hold_upd)
    );

    tip_avg #(.AVG_LOG2(AVG_LOG2)) u_avg (
        .clk      (clk),
        .rst      (rst),
        .start    (sync_rise),
        .smp_valid(adc_valid),
        .smp      (adc_data),
        .res      (avg)
    );

    tip_median #(.DEPTH(MED_DEPTH)) u_med (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (pend_val),
        .busy  (med_busy),
        .med_q (med_q),
        .med_ok(med_ok)
    );

    assign push = pend & ~hold_upd & ~med_busy;
    assign base = med_ok ? med_q : raw_q;

    always_comb begin
        if (state == ST_SEARCH || !raw_ok) thr = search_code;
        else if (burst_phase)              thr = add_sat(base, burst_ofs);
        else                               thr = add_sat(base, sync_ofs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            pend_val <= '0;
            raw_q    <= '0;
            raw_ok   <= 1'b0;
            dac_code <= '0;
        end else begin
            if (avg.valid) begin
                pend     <= 1'b1;
                pend_val <= avg.value;
            end else if (push) begin
                pend <= 1'b0;
            end
            if (push) begin
                raw_q  <= pend_val;
                raw_ok <= 1'b1;
            end
            dac_code <= thr;
        end
    end

    assign locked       = (state == ST_LOCK);
    assign median_ready = med_ok;
    assign tip_level    = base;

    // R5: once the window is full the median stays in use
    assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        median_ready |=> median_ready);

    // R6: the latest reading never changes during a burst window
    assert_defer_update_R6: assert property (@(posedge clk) disable iff (rst)
        (raw_q != $past(raw_q)) |-> !$past(burst_phase));
endmodule

// File: tb/test_sync_slice_tracker.sv
module test_sync_slice_tracker;
    localparam int LC    = 256;
    localparam int BMAX  = 40;
    localparam int STEP  = 64;
    localparam int TRUE_LVL = 600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_on = 1'b0;
    logic        cmp_in;
    logic        adc_valid = 1'b1;
    logic [11:0] adc_data = 12'd0;
    logic        burst_done = 1'b0;
    logic [11:0] sync_ofs = 12'd200;
    logic [11:0] burst_ofs = 12'd900;
    logic [7:0]  width_min = 8'd20;
    logic [7:0]  width_max = 8'd40;
    logic [11:0] dac_code;
    logic        locked, median_ready;
    logic [11:0] tip_level;

    int checks = 0;
    int errors = 0;
    int s_dac_a, s_tip_a, s_dac_b;
    int hist[$];

    always #5 clk = ~clk;

    assign cmp_in = sync_on && (int'(dac_code) > TRUE_LVL);

    sync_slice_tracker #(
        .LINE_CYCLES(LC),
        .BURST_MAX  (BMAX),
        .SEARCH_STEP(STEP)
    ) i_sync_slice_tracker (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .adc_valid(adc_valid),
        .adc_data(adc_data), .burst_done(burst_done), .sync_ofs(sync_ofs),
        .burst_ofs(burst_ofs), .width_min(width_min), .width_max(width_max),
        .dac_code(dac_code), .locked(locked), .median_ready(median_ready),
        .tip_level(tip_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int median_of(int q[$]);
        int a[23];
        int n;
        n = q.size();
        for (int i = 0; i < 23; i++) a[i] = q[n - 23 + i];
        for (int i = 0; i < 23; i++)
            for (int j = 0; j < 22 - i; j++)
                if (a[j] > a[j+1]) begin
                    int t;
                    t = a[j]; a[j] = a[j+1]; a[j+1] = t;
                end
        return a[11];
    endfunction

    function automatic int sat(int v);
        return (v > 4095) ? 4095 : v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sync_on = 1'b0;
        burst_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one 200-cycle line: pulse of w cycles, burst_done w+bd cycles in (bd<0: none)
    task automatic do_line(input int w, input int val, input bit ramp, input int bd);
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            sync_on    = (c < w);
            adc_data   = 12'(val + ((ramp && c < w) ? c : 0));
            burst_done = (bd >= 0) && (c == w + bd);
            if (c == w + 5)  begin s_dac_a = dac_code; s_tip_a = tip_level; end
            if (c == w + 60) s_dac_b = dac_code;
        end
    endtask

    task automatic bring_up();
        do_reset();
        for (int i = 0; i < 40; i++) begin
            do_line(30, TRUE_LVL, 1'b0, 10);
            if (dac_code == 12'd800) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(dac_code == 0, "R1 dac_code in reset", dac_code, 0);
        chk(locked == 0 && median_ready == 0, "R1 flags in reset", {locked, median_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dac_code == 0, "R1 dac_code after release", dac_code, 0);
    endtask

    task automatic t_search();
        do_reset();
        repeat (127) @(negedge clk);
        chk(dac_code == 0, "R2 first period", dac_code, 0);
        repeat (256) @(negedge clk);
        chk(dac_code == 64, "R2 second period", dac_code, 64);
        repeat (256) @(negedge clk);
        chk(dac_code == 128, "R2 third period", dac_code, 128);
        for (int i = 0; i < 20; i++) do_line(60, TRUE_LVL, 1'b0, 10);
        chk(dac_code >= 896 && dac_code % 64 == 0, "R11 wide pulses ignored", dac_code, 896);
        chk(locked == 0, "R11 no lock on wide pulses", locked, 0);
        for (int i = 0; i < 3; i++) do_line(30, TRUE_LVL, 1'b0, 10);
        chk(dac_code == 800, "R3 sync level after acquisition", dac_code, 800);
        chk(locked == 0, "R9 not locked yet", locked, 0);
        for (int i = 0; i < 20; i++) do_line(30, TRUE_LVL, 1'b0, 10);
        chk(locked == 1, "R9 locked after run of good pulses", locked, 1);
    endtask

    task automatic t_median();
        int m;
        bring_up();
        chk(median_ready == 0, "R5 not ready early", median_ready, 0);
        do_line(30, TRUE_LVL, 1'b1, 10);
        chk(s_tip_a == 600, "R6 level held in burst window", s_tip_a, 600);
        chk(s_dac_a == 1500, "R7 burst level", s_dac_a, 1500);
        chk(s_dac_b == 803, "R7 back to sync level", s_dac_b, 803);
        chk(tip_level == 603, "R4 truncated mean of ramp", tip_level, 603);
        do_line(30, 612, 1'b0, 30);
        chk(s_tip_a == 603, "R6 late burst_done defers update", s_tip_a, 603);
        chk(tip_level == 612, "R5 raw reading before ready", tip_level, 612);
        for (int i = 0; i < 30; i++) begin
            int v;
            v = 560 + (i * 37) % 97;
            do_line(30, v, 1'b0, 10);
            hist.push_back(v);
        end
        m = median_of(hist);
        chk(median_ready == 1, "R5 ready after window full", median_ready, 1);
        chk(tip_level == m, "R5 median of window", tip_level, m);
        chk(dac_code == m + 200, "R3 threshold from median", dac_code, m + 200);
        do_line(30, 3000, 1'b0, 10);
        hist.push_back(3000);
        m = median_of(hist);
        chk(tip_level == m, "R5 spike rejected by median", tip_level, m);
    endtask

    task automatic t_clamp();
        bring_up();
        @(negedge clk);
        sync_ofs = 12'd4000;
        repeat (3) @(negedge clk);
        chk(dac_code == 4095, "R3 saturation of sync level", dac_code, 4095);
        burst_ofs = 12'd3900;
        do_line(30, TRUE_LVL, 1'b0, 10);
        chk(s_dac_a == 4095, "R7 saturation of burst level", s_dac_a, 4095);
        sync_ofs = 12'd200;
        burst_ofs = 12'd900;
        repeat (3) @(negedge clk);
        chk(dac_code == 800, "R3 margin restored", dac_code, 800);
    endtask

    task automatic t_burst_timeout();
        bring_up();
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            sync_on = (c < 30);
            adc_data = 12'(TRUE_LVL);
            burst_done = 1'b0;
            if (c == 50) s_dac_a = dac_code;
            if (c == 90) s_dac_b = dac_code;
        end
        chk(s_dac_a == 1500, "R8 burst level while waiting", s_dac_a, 1500);
        chk(s_dac_b == 800, "R8 window closed without burst_done", s_dac_b, 800);
    endtask

    task automatic t_lock_restart();
        bring_up();
        for (int i = 0; i < 10; i++) do_line(30, TRUE_LVL, 1'b0, 10);
        do_line(10, TRUE_LVL, 1'b0, 10);
        for (int i = 0; i < 10; i++) do_line(30, TRUE_LVL, 1'b0, 10);
        chk(locked == 0, "R9 bad width restarts count", locked, 0);
        for (int i = 0; i < 8; i++) do_line(30, TRUE_LVL, 1'b0, 10);
        chk(locked == 1, "R9 lock after restarted count", locked, 1);
    endtask

    task automatic t_loss();
        @(negedge clk);
        sync_on = 1'b0;
        repeat (60 * LC) @(negedge clk);
        chk(locked == 1, "R10 lock held before 64 lines", locked, 1);
        repeat (7 * LC) @(negedge clk);
        chk(locked == 0, "R10 lock dropped", locked, 0);
        chk(dac_code <= 192, "R10 search restarted low", dac_code, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_search();
        t_median();
        t_clamp();
        t_burst_timeout();
        t_lock_restart();
        t_loss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule